// File: doc/BRIEF.md
# Block Variance Classifier

The classifier accepts the pixels of one square image block, BLK_N by BLK_N, in raster order. It holds the pixels in a block-sized window store. For every pixel position it forms the 3x3 neighbourhood centred on that position and derives a local variance measure from it. It labels each position as uniform, texture or edge by comparing that measure with two programmable thresholds.

The per-label totals decide which of six block classes the block falls into. The class selects a strong-edge percentage, P1, which a later hysteresis-threshold stage consumes. P1 is an 8-bit fraction with 8 fraction bits. P1 and the class are registered and announced by a one-cycle valid pulse.

A block begins with a start strobe that arrives together with its first pixel. The block then runs in three phases: a fill phase that stores BLK_N*BLK_N pixels, a scan phase that classifies one position per cycle, and one output cycle.

Top module: `blk_var_class`

## Requirements
- R1: While rst_ni is low, and after it is released until the first result, p1_o, class_o and p1_valid_o are all 0.
- R2: For each position the measure is V = (9*S2 - S1*S1) >> 3, where S1 is the sum and S2 the sum of squares of the nine window pixels. V is nine times the variance with divisor 8, rounded down. A window tap that falls outside the block takes the nearest pixel inside the block, with row and column clamped independently.
- R3: A position is uniform when V < uni_thr_i. Otherwise it is edge when V >= edge_thr_i, and texture in all remaining cases. Both compares are unsigned.
- R4: With E, T and U the edge, texture and uniform totals and M = BLK_N*BLK_N, class_o is chosen by the first matching rule. 10E >= 3M gives 5 (strong edge). 10E >= M gives 4 (medium edge). E > 0 and 10T >= 3M gives 3 (edge/texture). 10T >= 3M gives 2 (texture). U = M gives 0 (uniform). Any other block gives 1 (uniform/texture).
- R5: p1_o is 0 for classes 0 and 1, 8 for class 2, 26 for class 3, 51 for class 4 and 102 for class 5.
- R6: p1_valid_o is high for exactly one cycle, on the (M+1)th rising edge after the edge that accepts the block's last pixel. p1_o and class_o change only together with that pulse and hold their values otherwise.
- R7: A high sob_i clears the label totals and the write position, abandons any block in progress, and suppresses a pending result. The pixel presented with sob_i (when pix_valid_i is high) is stored as pixel 0.
- R8: pix_valid_i without sob_i is ignored during the scan and output phases and after a result. It changes no output and starts no block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sob_i | input | 1 | Start-of-block strobe, marks pixel 0 |
| pix_valid_i | input | 1 | Pixel qualifier |
| pix_i | input | PIX_W | Pixel intensity, unsigned |
| uni_thr_i | input | 2*PIX_W+4 | Uniform threshold on V |
| edge_thr_i | input | 2*PIX_W+4 | Edge threshold on V |
| p1_o | output | 8 | Strong-edge percentage, 8 fraction bits |
| class_o | output | 3 | Block class code, 0 to 5 |
| p1_valid_o | output | 1 | One-cycle result strobe |

## Verification
A start strobe can land in the same cycle as scan-phase counting, or in the same cycle as a pixel write. In both cases the clear must win, and the accompanying pixel must still be stored as pixel 0. The bench provokes the first collision by starting a new block five cycles into the scan of a flat block. It then requires that no result pulse appears before the new block's result, and that this result reports the new block's class with the full latency. The second collision is present in every block, because each block is opened by a strobe that carries its first pixel. A truncated block followed by a fresh one must still give the fresh block's exact class.

// File: rtl/bvc_pkg.sv
package bvc_pkg;

  typedef enum logic [1:0] {
    LBL_UNI  = 2'd0,
    LBL_TEX  = 2'd1,
    LBL_EDGE = 2'd2
  } lbl_e;

  typedef enum logic [2:0] {
    BT_UNI     = 3'd0,
    BT_UNITEX  = 3'd1,
    BT_TEX     = 3'd2,
    BT_EDGETEX = 3'd3,
    BT_MEDEDGE = 3'd4,
    BT_STRONG  = 3'd5
  } blk_e;

  // Q0.8 constants
  localparam logic [7:0] P1_TEX     = 8'd8;
  localparam logic [7:0] P1_EDGETEX = 8'd26;
  localparam logic [7:0] P1_MED     = 8'd51;
  localparam logic [7:0] P1_STRONG  = 8'd102;

  function automatic logic [7:0] p1_of(blk_e t);
    case (t)
      BT_TEX:     return P1_TEX;
      BT_EDGETEX: return P1_EDGETEX;
      BT_MEDEDGE: return P1_MED;
      BT_STRONG:  return P1_STRONG;
      default:    return 8'd0;
    endcase
  endfunction

endpackage

// File: rtl/bvc_win_buf.sv
module bvc_win_buf #(
  parameter int N  = 8,
  parameter int PW = 8,
  localparam int N2 = N * N,
  localparam int AW = $clog2(N),
  localparam int IW = $clog2(N2)
) (
  input  logic            clk_i,
  input  logic            wr_en_i,
  input  logic [IW-1:0]   wr_idx_i,
  input  logic [PW-1:0]   wr_pix_i,
  input  logic [AW-1:0]   row_i,
  input  logic [AW-1:0]   col_i,
  output logic [9*PW-1:0] win_o
);

  logic [PW-1:0] mem_q [N2];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_pix_i;
  end

  // nine taps, clamped at block borders
  for (genvar t = 0; t < 9; t++) begin : g_tap
    localparam int DR = t / 3 - 1;
    localparam int DC = t % 3 - 1;
    logic [AW-1:0] r, c;
    logic [IW-1:0] idx;

    always_comb begin
      r = row_i;
      c = col_i;
      if (DR < 0 && row_i != '0)           r = row_i - 1'b1;
      if (DR > 0 && row_i != AW'(N - 1))   r = row_i + 1'b1;
      if (DC < 0 && col_i != '0)           c = col_i - 1'b1;
      if (DC > 0 && col_i != AW'(N - 1))   c = col_i + 1'b1;
      idx = IW'(int'(r) * N + int'(c));
    end

    assign win_o[t*PW +: PW] = mem_q[idx];
  end

endmodule

// File: rtl/bvc_var_label.sv
module bvc_var_label
  import bvc_pkg::*;
#(
  parameter int PW = 8,
  localparam int DW = 2 * PW + 7,
  localparam int VW = DW - 3
) (
  input  logic [9*PW-1:0] win_i,
  input  logic [VW-1:0]   uni_thr_i,
  input  logic [VW-1:0]   edge_thr_i,
  output lbl_e            lbl_o
);

  logic [DW-1:0] s1, s2, d;
  logic [VW-1:0] v;

  always_comb begin
    s1 = '0;
    s2 = '0;
    for (int t = 0; t < 9; t++) begin
      s1 = s1 + DW'(win_i[t*PW +: PW]);
      s2 = s2 + DW'(win_i[t*PW +: PW]) * DW'(win_i[t*PW +: PW]);
    end
    // 9*sum of squared deviations; never negative
    d = DW'(9) * s2 - s1 * s1;
    v = d[DW-1:3];
  end

  always_comb begin
    if (v < uni_thr_i)        lbl_o = LBL_UNI;
    else if (v >= edge_thr_i) lbl_o = LBL_EDGE;
    else                      lbl_o = LBL_TEX;
  end

endmodule

// File: rtl/bvc_decide.sv
module bvc_decide
  import bvc_pkg::*;
#(
  parameter int N2 = 64,
  localparam int CW = $clog2(N2 + 1),
  localparam int MW = CW + 4
) (
  input  logic [CW-1:0] cnt_uni_i,
  input  logic [CW-1:0] cnt_tex_i,
  input  logic [CW-1:0] cnt_edge_i,
  output blk_e          cls_o
);

  localparam logic [MW-1:0] FRAC30 = MW'(3 * N2);
  localparam logic [MW-1:0] FRAC10 = MW'(N2);

  logic hi_edge, lo_edge, hi_tex, all_uni;
  blk_e edge_path, tex_path;

  assign hi_edge = MW'(10) * MW'(cnt_edge_i) >= FRAC30;
  assign lo_edge = MW'(10) * MW'(cnt_edge_i) >= FRAC10;
  assign hi_tex  = MW'(10) * MW'(cnt_tex_i)  >= FRAC30;
  assign all_uni = cnt_uni_i == CW'(N2);

  // level 1
  assign edge_path = hi_edge ? BT_STRONG : BT_MEDEDGE;
  always_comb begin
    if (hi_tex)       tex_path = (cnt_edge_i != '0) ? BT_EDGETEX : BT_TEX;
    else              tex_path = all_uni ? BT_UNI : BT_UNITEX;
  end

  // level 2
  assign cls_o = lo_edge ? edge_path : tex_path;

endmodule

// File: rtl/blk_var_class.sv
module blk_var_class
  import bvc_pkg::*;
#(
  parameter int BLK_N = 8,
  parameter int PIX_W = 8,
  localparam int VW = 2 * PIX_W + 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sob_i,
  input  logic             pix_valid_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic [VW-1:0]    uni_thr_i,
  input  logic [VW-1:0]    edge_thr_i,
  output logic [7:0]       p1_o,
  output logic [2:0]       class_o,
  output logic             p1_valid_o
);

  localparam int N2 = BLK_N * BLK_N;
  localparam int AW = $clog2(BLK_N);
  localparam int IW = $clog2(N2);
  localparam int CW = $clog2(N2 + 1);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_SCAN, S_OUT} st_e;

  st_e           st_q;
  logic [IW-1:0] ptr_q;
  logic [AW-1:0] row_q, col_q;
  logic [CW-1:0] cnt_u_q, cnt_t_q, cnt_e_q;

  logic            wr_en;
  logic [IW-1:0]   wr_idx;
  logic [9*PIX_W-1:0] win;
  lbl_e            lbl;
  blk_e            cls;

  assign wr_en  = pix_valid_i && (sob_i || st_q == S_FILL);
  assign wr_idx = sob_i ? '0 : ptr_q;

  bvc_win_buf #(.N(BLK_N), .PW(PIX_W)) u_buf (
    .clk_i   (clk_i),
    .wr_en_i (wr_en),
    .wr_idx_i(wr_idx),
    .wr_pix_i(pix_i),
    .row_i   (row_q),
    .col_i   (col_q),
    .win_o   (win)
  );

  bvc_var_label #(.PW(PIX_W)) u_lbl (
    .win_i     (win),
    .uni_thr_i (uni_thr_i),
    .edge_thr_i(edge_thr_i),
    .lbl_o     (lbl)
  );

  bvc_decide #(.N2(N2)) u_dec (
    .cnt_uni_i (cnt_u_q),
    .cnt_tex_i (cnt_t_q),
    .cnt_edge_i(cnt_e_q),
    .cls_o     (cls)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      ptr_q      <= '0;
      row_q      <= '0;
      col_q      <= '0;
      cnt_u_q    <= '0;
      cnt_t_q    <= '0;
      cnt_e_q    <= '0;
      p1_o       <= '0;
      class_o    <= '0;
      p1_valid_o <= 1'b0;
    end else begin
      p1_valid_o <= 1'b0;
      if (sob_i) begin
        // clear wins over counting and output
        st_q    <= S_FILL;
        ptr_q   <= IW'(pix_valid_i);
        row_q   <= '0;
        col_q   <= '0;
        cnt_u_q <= '0;
        cnt_t_q <= '0;
        cnt_e_q <= '0;
      end else begin
        case (st_q)
          S_FILL: if (pix_valid_i) begin
            ptr_q <= ptr_q + 1'b1;
            if (ptr_q == IW'(N2 - 1)) begin
              st_q  <= S_SCAN;
              row_q <= '0;
              col_q <= '0;
            end
          end
          S_SCAN: begin
            case (lbl)
              LBL_UNI:  cnt_u_q <= cnt_u_q + 1'b1;
              LBL_TEX:  cnt_t_q <= cnt_t_q + 1'b1;
              default:  cnt_e_q <= cnt_e_q + 1'b1;
            endcase
            if (col_q == AW'(BLK_N - 1)) begin
              col_q <= '0;
              if (row_q == AW'(BLK_N - 1)) st_q <= S_OUT;
              else                         row_q <= row_q + 1'b1;
            end else begin
              col_q <= col_q + 1'b1;
            end
          end
          S_OUT: begin
            p1_o       <= p1_of(cls);
            class_o    <= cls;
            p1_valid_o <= 1'b1;
            st_q       <= S_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/bvc_chk.sv
module bvc_chk
  import bvc_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sob_i,
  input logic       p1_valid_o,
  input logic [7:0] p1_o,
  input logic [2:0] class_o
);

  // R6
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p1_valid_o |=> !p1_valid_o);

  // R6
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !p1_valid_o |-> ($stable(p1_o) && $stable(class_o)));

  // R4
  class_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    class_o <= 3'd5);

  // R5
  p1_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p1_valid_o |-> (p1_o == p1_of(blk_e'(class_o))));

  // R7
  sob_kill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sob_i |=> !p1_valid_o);

endmodule

bind blk_var_class bvc_chk u_bvc_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sob_i     (sob_i),
  .p1_valid_o(p1_valid_o),
  .p1_o      (p1_o),
  .class_o   (class_o)
);

// File: tb/tb_blk_var_class.sv
module tb_blk_var_class;

  localparam int N  = 8;
  localparam int PW = 8;
  localparam int VW = 2 * PW + 4;
  localparam int N2 = N * N;
  localparam int VMAX = (1 << VW) - 1;

  typedef struct packed {
    logic [31:0] pat;
    logic [31:0] uni;
    logic [31:0] edg;
    logic [31:0] cls;
    logic [31:0] p1;
  } vec_t;

  // patterns: 0 flat, 1 checker 0/255, 2 vertical step, 3 small checker + bright corner
  localparam vec_t VECS [9] = '{
    '{32'd0, 32'd1,      32'd2,      32'd0, 32'd0},
    '{32'd1, 32'd1,      32'd2,      32'd5, 32'd102},
    '{32'd1, 32'd1,      VMAX,       32'd2, 32'd8},
    '{32'd2, 32'd1,      32'd2,      32'd4, 32'd51},
    '{32'd2, 32'd1,      VMAX,       32'd1, 32'd0},
    '{32'd3, 32'd5,      32'd1000,   32'd3, 32'd26},
    '{32'd2, 32'd1,      32'd146306, 32'd4, 32'd51},
    '{32'd2, 32'd1,      32'd146307, 32'd1, 32'd0},
    '{32'd2, 32'd146307, VMAX,       32'd0, 32'd0}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sob;
  logic          pv;
  logic [PW-1:0] pix;
  logic [VW-1:0] uni_thr, edge_thr;
  logic [7:0]    p1;
  logic [2:0]    cls;
  logic          p1_valid;

  int n_run  = 0;
  int n_fail = 0;
  int n_seen = 0;

  always #2 clk = ~clk;

  blk_var_class #(.BLK_N(N), .PIX_W(PW)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .sob_i      (sob),
    .pix_valid_i(pv),
    .pix_i      (pix),
    .uni_thr_i  (uni_thr),
    .edge_thr_i (edge_thr),
    .p1_o       (p1),
    .class_o    (cls),
    .p1_valid_o (p1_valid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int pix_of(input int pat, input int r, input int c);
    case (pat)
      0: return 100;
      1: return ((r + c) % 2 == 1) ? 255 : 0;
      2: return (c >= N / 2) ? 255 : 0;
      default: return (r == 0 && c == 0) ? 255 : (((r + c) % 2 == 1) ? 2 : 0);
    endcase
  endfunction

  // full block; counts any result pulse seen while feeding
  task automatic feed(input int pat);
    n_seen = 0;
    for (int i = 0; i < N2; i++) begin
      @(negedge clk);
      if (p1_valid) n_seen++;
      sob = (i == 0);
      pv  = 1'b1;
      pix = PW'(pix_of(pat, i / N, i % N));
    end
    @(negedge clk);
    sob = 1'b0;
    pv  = 1'b0;
  endtask

  task automatic wait_res(output int lat);
    lat = 0;
    while (!p1_valid && lat < 4 * N2) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R6 act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int lat;
    string tag;
    rst_n    = 1'b0;
    sob      = 1'b0;
    pv       = 1'b0;
    pix      = '0;
    uni_thr  = '0;
    edge_thr = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 p1", int'(p1), 0);
    chk("R1 class", int'(cls), 0);
    chk("R1 valid", int'(p1_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 valid after release", int'(p1_valid), 0);

    // vector table: R2 window/clamp, R3 compare edges, R4 class rules
    for (int i = 0; i < 9; i++) begin
      uni_thr  = VW'(VECS[i].uni);
      edge_thr = VW'(VECS[i].edg);
      tag = (i >= 6) ? "R3 threshold boundary" : (i == 5) ? "R2 clamped corner" : "R4 class";
      feed(int'(VECS[i].pat));
      wait_res(lat);
      chk(tag, int'(cls), int'(VECS[i].cls));
      chk("R5 p1", int'(p1), int'(VECS[i].p1));
      chk("R6 latency", lat, N2 + 1);
      @(negedge clk);
      chk("R6 pulse width", int'(p1_valid), 0);
    end

    // R7: truncated block then a fresh flat block
    uni_thr  = VW'(1);
    edge_thr = VW'(2);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      sob = (i == 0);
      pv  = 1'b1;
      pix = PW'(pix_of(1, i / N, i % N));
    end
    feed(0);
    wait_res(lat);
    chk("R7 truncated block discarded", int'(cls), 0);
    chk("R7 latency", lat, N2 + 1);

    // R7: strobe five cycles into a scan aborts it
    feed(0);
    repeat (4) @(negedge clk);
    feed(1);
    chk("R7 no stale result", n_seen, 0);
    wait_res(lat);
    chk("R7 new block class", int'(cls), 5);
    chk("R7 new block latency", lat, N2 + 1);
    @(negedge clk);

    // R8: pixels after a result start nothing
    n_seen = 0;
    for (int i = 0; i < 3 * N2; i++) begin
      @(negedge clk);
      if (p1_valid) n_seen++;
      pv  = 1'b1;
      pix = PW'(i * 37);
    end
    @(negedge clk);
    if (p1_valid) n_seen++;
    pv = 1'b0;
    chk("R8 idle pixels no result", n_seen, 0);
    chk("R8 p1 held", int'(p1), 102);
    chk("R8 class held", int'(cls), 5);

    // R8: pixels during scan leave the block unchanged
    feed(0);
    pv  = 1'b1;
    pix = 8'd255;
    wait_res(lat);
    pv = 1'b0;
    chk("R8 scan pixels ignored", int'(cls), 0);
    chk("R8 p1", int'(p1), 0);
    chk("R8 latency", lat, N2 + 1);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule